// File: doc/BRIEF.md
# Two-Port Memory Self-Test Sequencer

This block runs a March-style self-test on a 128-word by 25-bit memory. The memory has a write-only port and a read-only port, each with its own address bus, and both are clocked on the sequencer's clock. The sequencer writes solid backgrounds (all zeros, then all ones) through the write port and reads each word back through the read port. One cycle after each read it compares the returned word with the value it expects.

A pulse on `start` begins a run. When the last comparison has been made, `done` rises and stays high. `fail` reports whether any word differed from its expected value, and `fail_addr` holds the address of the first word that differed. Every step that reads a word and then rewrites it is split in two. The read of address a is issued in one cycle. The write to a follows in the next cycle, while the read of the following address goes out on the other port. As a result, the two ports never point at the same word in the same cycle, and the read data is never undefined.

Top module: `tpb_ctrl`

## Requirements
- R1: After reset and whenever no run is in progress, `done` and `fail` are low until a run sets them. `fail_addr` is 0 after reset. `rd_csn`, `wr_csn` and `wr_wen` are all high (inactive).
- R2: A `start` pulse sampled while no run is in progress begins a run. `done` rises at the 774th clock edge after the edge that sampled `start` (6 elements of 129 cycles each). It then stays high until the next accepted `start`.
- R3: In no cycle does an active read (`rd_csn` low) and an active write (`wr_csn` and `wr_wen` low) use the same address.
- R4: A run consists of six elements in this order: write 0; read 0 and write 1; read 1 and write 0; read 0 and write 1; read 1 and write 0; read 0. Here "0" is a word of all zeros and "1" is a word of all ones. Every write carries a word whose bits are all equal. A run makes exactly 640 reads and 640 writes.
- R5: In each read-then-write element, the write to address a is issued in the cycle directly after the read of a. That gives 512 such read-write pairs per run.
- R6: Elements 2, 3 and 6 read in ascending order from 0 to 127. Elements 4 and 5 read in descending order from 127 to 0. This gives 381 ascending and 254 descending single steps between back-to-back reads.
- R7: Each read word is compared in the cycle after its read is issued. On a fault-free memory a run ends with `fail` low.
- R8: A bit stuck at 1 or stuck at 0 in any word makes the run end with `fail` high and `fail_addr` equal to the address of that word.
- R9: `fail_addr` keeps the address of the first miscompare of a run, even when later words also fail. `fail` stays high until the next accepted `start`, which clears both `fail` and `fail_addr`.
- R10: A `start` pulse during a run has no effect: `done` still rises 774 edges after the original start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and both memory ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when no run is in progress |
| done | output | 1 | High once the run has finished |
| fail | output | 1 | High after any miscompare in the run |
| fail_addr | output | 7 | Address of the first miscompare |
| rd_csn | output | 1 | Read-port chip select, active low |
| rd_addr | output | 7 | Read-port address |
| rd_data | input | 25 | Word returned by the read port one cycle after the read |
| wr_csn | output | 1 | Write-port chip select, active low |
| wr_wen | output | 1 | Write enable, active low |
| wr_addr | output | 7 | Write-port address |
| wr_data | output | 25 | Word to be written |

## Verification
The hardest condition to produce from the ports is a read and a write meeting on one word. With a correct sequencer this never happens, so the bench's memory model turns any such meeting into an undefined read word and counts it. A per-cycle monitor counts collisions and checks that every write lands on the word read one cycle before it. It also counts ascending and descending address steps, which shows the address order at the element boundaries, where the descending elements begin at the last address written.

Detection is shown by stuck bits that the memory model forces onto chosen words. One run places a stuck-at-1 fault at a high address and a stuck-at-0 fault at a low address. The stuck-at-1 fault fails in the second element and the stuck-at-0 fault only later, so a run that reports the lower or the later address is caught.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  localparam int NUM_ELEM = 6;

  typedef logic [2:0] elem_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} run_st_t;

  // Element 0 only writes; element 5 only reads; the rest read then write.
  function automatic logic elem_reads(input elem_t e);
    return e != 3'd0;
  endfunction

  function automatic logic elem_writes(input elem_t e);
    return e <= 3'd4;
  endfunction

  function automatic logic elem_down(input elem_t e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  // Background expected on reads: 1 in elements 2 and 4, else 0.
  function automatic logic elem_rd_bg(input elem_t e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

  // Background written: 1 in elements 1 and 3, else 0.
  function automatic logic elem_wr_bg(input elem_t e);
    return (e == 3'd1) || (e == 3'd3);
  endfunction
endpackage

// File: rtl/tpb_seq.sv
module tpb_seq
  import tpb_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          running,
  output logic          finished,
  output logic          start_accept,
  output elem_t         elem,
  output logic [AW:0]   idx
);
  // idx runs 0 .. 2**AW; the last value is a drain step with no read.
  localparam logic [AW:0] DRAIN_IDX = (AW+1)'(1 << AW);
  localparam elem_t       LAST_ELEM = 3'(NUM_ELEM - 1);

  run_st_t st;

  assign running      = (st == ST_RUN);
  assign finished     = (st == ST_DONE);
  assign start_accept = start && (st != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      elem <= '0;
      idx  <= '0;
    end else if (start_accept) begin
      st   <= ST_RUN;
      elem <= '0;
      idx  <= '0;
    end else if (st == ST_RUN) begin
      if (idx == DRAIN_IDX) begin
        idx <= '0;
        if (elem == LAST_ELEM) st <= ST_DONE;
        else                   elem <= elem + 3'd1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpb_port.sv
module tpb_port
  import tpb_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 25
) (
  input  logic          running,
  input  elem_t         elem,
  input  logic [AW:0]   idx,
  output logic          rd_fire,
  output logic          rd_csn,
  output logic [AW-1:0] rd_addr,
  output logic          exp_bg,
  output logic          wr_csn,
  output logic          wr_wen,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  // Step number to address: descending elements mirror the step.
  function automatic logic [AW-1:0] step_to_addr(input logic [AW:0] step, input logic down);
    return down ? ~step[AW-1:0] : step[AW-1:0];
  endfunction

  logic          rd_elem;
  logic          wr_fire;
  logic [AW:0]   wr_step;

  assign rd_elem = elem_reads(elem);
  assign rd_fire = running && rd_elem && !idx[AW];
  assign rd_addr = step_to_addr(idx, elem_down(elem));
  assign rd_csn  = !rd_fire;
  assign exp_bg  = elem_rd_bg(elem);

  // In read-then-write elements the write trails the read by one step.
  assign wr_step = rd_elem ? (idx - 1'b1) : idx;
  assign wr_fire = running && elem_writes(elem) &&
                   (rd_elem ? (idx != '0) : !idx[AW]);
  assign wr_addr = step_to_addr(wr_step, elem_down(elem));
  assign wr_csn  = !wr_fire;
  assign wr_wen  = !wr_fire;
  assign wr_data = {DW{elem_wr_bg(elem)}};
endmodule

// File: rtl/tpb_cmp.sv
module tpb_cmp #(
  parameter int AW = 7,
  parameter int DW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rd_fire,
  input  logic [AW-1:0] rd_addr,
  input  logic          exp_bg,
  input  logic [DW-1:0] rd_data,
  output logic          cmp_valid,
  output logic          miscompare,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  logic          cmp_bg;
  logic [AW-1:0] cmp_addr;

  // One pipeline stage between issuing a read and checking its word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_valid <= 1'b0;
      cmp_bg    <= 1'b0;
      cmp_addr  <= '0;
    end else begin
      cmp_valid <= rd_fire;
      cmp_bg    <= exp_bg;
      cmp_addr  <= rd_addr;
    end
  end

  assign miscompare = cmp_valid && (rd_data != {DW{cmp_bg}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (miscompare && !fail) begin
      fail      <= 1'b1;
      fail_addr <= cmp_addr;
    end
  end
endmodule

// File: rtl/tpb_ctrl.sv
module tpb_ctrl
  import tpb_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic          rd_csn,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_csn,
  output logic          wr_wen,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic        running;
  logic        start_accept;
  logic        rd_fire;
  logic        exp_bg;
  logic        cmp_valid;
  logic        miscompare;
  elem_t       elem;
  logic [AW:0] idx;

  tpb_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .running(running), .finished(done), .start_accept(start_accept),
    .elem(elem), .idx(idx)
  );

  tpb_port #(.AW(AW), .DW(DW)) u_port (
    .running(running), .elem(elem), .idx(idx),
    .rd_fire(rd_fire), .rd_csn(rd_csn), .rd_addr(rd_addr), .exp_bg(exp_bg),
    .wr_csn(wr_csn), .wr_wen(wr_wen), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  tpb_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(start_accept),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .exp_bg(exp_bg), .rd_data(rd_data),
    .cmp_valid(cmp_valid), .miscompare(miscompare),
    .fail(fail), .fail_addr(fail_addr)
  );
endmodule

// File: rtl/tpb_chk.sv
module tpb_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic          start_accept,
  input logic          cmp_valid,
  input logic          fail,
  input logic [AW-1:0] fail_addr,
  input logic          rd_csn,
  input logic [AW-1:0] rd_addr,
  input logic          wr_csn,
  input logic          wr_wen,
  input logic [AW-1:0] wr_addr
);
  // R1: ports stay quiet outside a run
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (rd_csn && wr_csn && wr_wen));

  // R3: never read and write one word in the same cycle
  p_no_collision_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_csn && !wr_csn && !wr_wen) |-> (rd_addr != wr_addr));

  // R7: a compare follows every read by exactly one cycle
  p_cmp_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_csn |=> cmp_valid);
  p_no_cmp_without_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_csn |=> !cmp_valid);

  // R9: fail and first address hold until a new run is accepted
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start_accept) |=> fail);
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start_accept) |=> $stable(fail_addr));
endmodule

bind tpb_ctrl tpb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .start_accept(start_accept),
  .cmp_valid(cmp_valid), .fail(fail), .fail_addr(fail_addr),
  .rd_csn(rd_csn), .rd_addr(rd_addr),
  .wr_csn(wr_csn), .wr_wen(wr_wen), .wr_addr(wr_addr)
);

// File: tb/tpb_ctrl_tb.sv
module tpb_ctrl_tb;
  localparam int AW = 7;
  localparam int DW = 25;
  localparam int WORDS = 1 << AW;
  localparam int RUN_CYCLES = 774;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done, fail;
  logic [AW-1:0] fail_addr;
  logic          rd_csn, wr_csn, wr_wen;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #4ns clk = ~clk;

  tpb_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
    .fail_addr(fail_addr), .rd_csn(rd_csn), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_csn(wr_csn), .wr_wen(wr_wen), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Memory model with injectable stuck bits; a collision returns X.
  logic [DW-1:0] mem [WORDS];
  logic          sa1_en = 1'b0, sa0_en = 1'b0;
  int            sa1_addr = 0, sa1_bit = 0, sa0_addr = 0, sa0_bit = 0;

  function automatic logic [DW-1:0] faulty(input int a, input logic [DW-1:0] w);
    logic [DW-1:0] r = w;
    if (sa1_en && a == sa1_addr) r[sa1_bit] = 1'b1;
    if (sa0_en && a == sa0_addr) r[sa0_bit] = 1'b0;
    return r;
  endfunction

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    rd_data = '0;
  end

  always @(posedge clk) begin
    if (!rd_csn) begin
      if (!wr_csn && !wr_wen && wr_addr == rd_addr) rd_data <= 'x;
      else rd_data <= faulty(int'(rd_addr), mem[rd_addr]);
    end
    if (!wr_csn && !wr_wen) mem[wr_addr] <= wr_data;
  end

  // Per-cycle port monitor
  int   m_rd, m_wr, m_coll, m_pair, m_pair_bad, m_up, m_down, m_wbad;
  logic prev_rd = 1'b0;
  int   prev_addr = 0;

  task automatic clear_mon();
    m_rd = 0; m_wr = 0; m_coll = 0; m_pair = 0; m_pair_bad = 0;
    m_up = 0; m_down = 0; m_wbad = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!wr_csn && !wr_wen) begin
        m_wr++;
        if (wr_data != '0 && wr_data != '1) m_wbad++;
        if (prev_rd) begin
          if (int'(wr_addr) == prev_addr) m_pair++;
          else m_pair_bad++;
        end
      end
      if (!rd_csn) begin
        m_rd++;
        if (!wr_csn && !wr_wen && wr_addr == rd_addr) m_coll++;
        if (prev_rd && int'(rd_addr) == prev_addr + 1) m_up++;
        if (prev_rd && int'(rd_addr) == prev_addr - 1) m_down++;
      end
      prev_rd   = !rd_csn;
      prev_addr = int'(rd_addr);
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(inout int cnt);
    while (!done && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic set_faults(input logic e1, input int a1, input int b1,
                            input logic e0, input int a0, input int b0);
    sa1_en = e1; sa1_addr = a1; sa1_bit = b1;
    sa0_en = e0; sa0_addr = a0; sa0_bit = b0;
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(fail == 1'b0, "R1 fail", int'(fail), 0);
    check(fail_addr == '0, "R1 fail_addr", int'(fail_addr), 0);
    check(rd_csn && wr_csn && wr_wen, "R1 strobes idle",
          int'({rd_csn, wr_csn, wr_wen}), 7);
  endtask

  task automatic t_clean_run();
    int cnt = 0;
    set_faults(1'b0, 0, 0, 1'b0, 0, 0);
    clear_mon();
    pulse_start();
    wait_done(cnt);
    check(cnt == RUN_CYCLES, "R2 run length", cnt, RUN_CYCLES);
    check(done == 1'b1, "R2 done", int'(done), 1);
    check(fail == 1'b0, "R7 clean memory passes", int'(fail), 0);
    check(m_coll == 0, "R3 collisions", m_coll, 0);
    check(m_rd == 640, "R4 read count", m_rd, 640);
    check(m_wr == 640, "R4 write count", m_wr, 640);
    check(m_wbad == 0, "R4 solid write data", m_wbad, 0);
    check(m_pair == 512 && m_pair_bad == 0, "R5 write follows read", m_pair, 512);
    check(m_up == 381, "R6 ascending steps", m_up, 381);
    check(m_down == 254, "R6 descending steps", m_down, 254);
    repeat (5) @(negedge clk);
    check(done && rd_csn && wr_csn && wr_wen, "R1 quiet after run",
          int'({done, rd_csn, wr_csn, wr_wen}), 15);
  endtask

  task automatic t_fault(input logic e1, input int a1, input int b1,
                         input logic e0, input int a0, input int b0,
                         input int exp_addr, input string req);
    int cnt = 0;
    set_faults(e1, a1, b1, e0, a0, b0);
    clear_mon();
    pulse_start();
    wait_done(cnt);
    check(fail == 1'b1, req, int'(fail), 1);
    check(int'(fail_addr) == exp_addr, req, int'(fail_addr), exp_addr);
    check(m_coll == 0, "R3 collisions under fault", m_coll, 0);
  endtask

  task automatic t_restart();
    int cnt = 0;
    set_faults(1'b0, 0, 0, 1'b0, 0, 0);
    pulse_start();
    check(fail == 1'b0 && fail_addr == '0, "R9 start clears fail",
          int'(fail_addr), 0);
    check(done == 1'b0, "R2 start clears done", int'(done), 0);
    wait_done(cnt);
    check(fail == 1'b0, "R9 clean rerun passes", int'(fail), 0);
  endtask

  task automatic t_start_ignored();
    int cnt = 0;
    pulse_start();
    repeat (300) begin
      @(negedge clk);
      cnt++;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt++;
    wait_done(cnt);
    check(cnt == RUN_CYCLES, "R10 start during run ignored", cnt, RUN_CYCLES);
    check(fail == 1'b0, "R10 run still clean", int'(fail), 0);
  endtask

  initial begin
    #2000us;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean_run();
    // R8: stuck-at-1 at word 37 bit 5
    t_fault(1'b1, 37, 5, 1'b0, 0, 0, 37, "R8 stuck-at-1");
    // R8: stuck-at-0 at word 90 bit 24
    t_fault(1'b0, 0, 0, 1'b1, 90, 24, 90, "R8 stuck-at-0");
    // R9: word 100 fails in element 1, word 10 only later
    t_fault(1'b1, 100, 3, 1'b1, 10, 0, 100, "R9 first failing address");
    t_restart();
    t_start_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule